// File: doc/BRIEF.md
# Two-Wire Slave Register Space with Persistent Pointer

This block is a slave on a two-wire serial bus. Through it an external master reaches a 256-byte register space held inside the block. The block samples the clock and data lines with the system clock, passing them through a synchronizer before it detects edges. It recognises START and STOP conditions. It answers only to a 7-bit device address made of the fixed prefix `1010` followed by three strap inputs. On the data line it does nothing but pull low. That pull-down is modelled as an output enable.

A word pointer decides which byte is read or written. It is loaded by the first byte after a write-addressed header, and it advances after every byte that is read or stored. After FFh it wraps to 00h. The pointer keeps its value from one transaction to the next. This allows three kinds of read: a read that simply continues from where the last access stopped, a read at any address (a header-only write sets the pointer, then a repeated START begins the read), and a sequential burst that runs for as long as the master acknowledges.

There is no streaming interface at the edge of the block. All of its traffic travels over the two bus lines, and the strap pins are static control inputs.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset the data-line pull-down is released, the pointer is 00h, and every storage byte reads 00h.
- R2: The slave responds only when the first seven bits after a START equal `1010` followed by strap bits 2,1,0 (MSB first). On any other address it pulls SDA low at no point before the next START or STOP, and its pointer and storage do not change.
- R3: The slave acknowledges, by pulling SDA low for the ninth clock, a matching device address, the pointer byte, and every data byte written.
- R4: In a write transaction (R/W bit, the eighth bit, is 0), the first byte loads the pointer. Each later complete byte is stored at the pointer, and the pointer then increments.
- R5: A read transaction (R/W = 1) returns, MSB first, the byte at the current pointer. The pointer keeps its value across STOP and START.
- R6: A random read works as follows: a write header and one pointer byte, then a repeated START and a read header. It returns the byte at the newly loaded address.
- R7: In a read, each master acknowledge (SDA low on the ninth clock) makes the slave send the byte at the next address. A master not-acknowledge ends the transfer with SDA released. After a read the pointer is one past the last byte sent.
- R8: Pointer increments wrap from FFh to 00h, for both reads and writes.
- R9: A STOP or START that arrives mid-byte abandons the transfer. It leaves the pointer unchanged and stores nothing. A START begins reception of a new device address.
- R10: The SDA pull-down changes only while SCL is low and is held constant through each SCL-high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | When 1, the pad pulls the data line low |

## Verification
Every strap setting is paired with every possible low address, so only an exact match gets an acknowledge. The wrong-prefix and near-miss headers show that the slave stays silent. The full space is filled with a bijective arithmetic pattern using a single burst that wraps, and then read back in one long acknowledged burst. This separates pointer-increment and wrap faults from storage faults, because every address holds a distinct value. Short current, random and wrap-straddling reads, together with transfers cut off by STOP or by a repeated START in the middle of a byte, distinguish a pointer that persists correctly from one that is reset, advanced twice, or loaded by a partial byte.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } i2cmem_state_e;

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else if (g == 0) begin
          scl_q[g] <= scl_i;
          sda_q[g] <= sda_i;
        end else begin
          scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
          sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cmem_regfile.sv
module i2cmem_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter int               AW       = 8,
  parameter int               DW       = 8,
  parameter int               STRAP_W  = 3,
  parameter int               PREFIX_W = 4,
  parameter logic [PREFIX_W-1:0] PREFIX = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_s,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic [AW-1:0]      ptr,
  output logic               we,
  output logic [AW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data,
  output logic               sda_oe
);

  localparam int                DEV_W = PREFIX_W + STRAP_W;
  localparam int                CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DW);

  i2cmem_state_e    st;
  logic [DW-1:0]    sh, tx;
  logic [CNT_W-1:0] cnt;
  logic             rw, mack;
  logic             match;

  assign match = (sh[DW-1 -: DEV_W] == {PREFIX, strap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      we      <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      we <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        unique case (st)
          ST_DEV, ST_PTR, ST_WR: begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          ST_RD:     cnt  <= cnt + 1'b1;
          ST_RD_ACK: mack <= ~sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (st)
          ST_DEV: if (cnt == FULL) begin
            if (match) begin
              st     <= ST_DEV_ACK;
              sda_oe <= 1'b1;
              rw     <= sh[0];
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_DEV_ACK: begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              st     <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_PTR;
            end
          end
          ST_PTR: if (cnt == FULL) begin
            ptr    <= sh[AW-1:0];
            sda_oe <= 1'b1;
            st     <= ST_PTR_ACK;
          end
          ST_WR: if (cnt == FULL) begin
            we      <= 1'b1;
            wr_addr <= ptr;
            wr_data <= sh;
            ptr     <= ptr + 1'b1;
            sda_oe  <= 1'b1;
            st      <= ST_WR_ACK;
          end
          ST_PTR_ACK, ST_WR_ACK: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_WR;
          end
          ST_RD: begin
            if (cnt == FULL) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              st     <= ST_RD_ACK;
            end else begin
              tx     <= {tx[DW-2:0], 1'b0};
              sda_oe <= ~tx[DW-2];
            end
          end
          ST_RD_ACK: begin
            if (mack) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              cnt    <= '0;
              st     <= ST_RD;
            end else begin
              st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave #(
  parameter int                  AW          = 8,
  parameter int                  DW          = 8,
  parameter int                  STRAP_W     = 3,
  parameter int                  PREFIX_W    = 4,
  parameter logic [PREFIX_W-1:0] PREFIX      = 4'b1010,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o
);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          we;

  i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cmem_ctrl #(
    .AW(AW), .DW(DW), .STRAP_W(STRAP_W), .PREFIX_W(PREFIX_W), .PREFIX(PREFIX)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap_i),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .we        (we),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o)
  );

  i2cmem_regfile #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/i2cmem_slave_chk.sv
module i2cmem_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input logic          we,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr,
  input logic          sda_oe_o
);

  p_reset_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe_o && ptr == '0));

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

  p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);

  p_ptr_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(scl_fall));

  p_write_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (ptr == AW'(wr_addr + 1'b1)));  // R8 wrap included

endmodule

bind i2cmem_slave i2cmem_slave_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .we        (we),
  .wr_addr   (wr_addr),
  .ptr       (ptr),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/i2cmem_slave_tb.sv
module i2cmem_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'b011;
  logic       sda_oe;
  logic       sda_line;

  int total = 0;
  int bad = 0;
  int oe_hi_viol = 0;
  int oe_toggles = 0;
  logic oe_seen = 1'b0;
  logic oe_prev = 1'b0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cmem_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .sda_oe_o (sda_oe)
  );

  // R10 monitor: pull-down may only move while SCL is low
  always @(negedge clk) begin
    if (sda_oe !== oe_prev) begin
      oe_toggles++;
      if (scl) oe_hi_viol++;
    end
    oe_prev <= sda_oe;
    if (sda_oe) oe_seen <= 1'b1;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      m_sda = 1'b1; hw(H);
      scl = 1'b1;   hw(H);
    end
    m_sda = 1'b0; hw(H);
    scl = 1'b0;   hw(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw(H);
    scl = 1'b1;   hw(H);
    m_sda = 1'b1; hw(H);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hw(H);
      scl = 1'b1;   hw(H);
      scl = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    m_sda = 1'b1; hw(H);
    scl = 1'b1;   hw(H/2);
    ack = ~sda_line; hw(H/2);
    scl = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hw(H);
      scl = 1'b1;   hw(H/2);
      b[i] = sda_line; hw(H/2);
      scl = 1'b0;
    end
    m_sda = ~give_ack; hw(H);
    scl = 1'b1;        hw(H);
    scl = 1'b0;
  endtask

  function automatic logic [7:0] hdr(input logic [2:0] lo, input logic rw);
    return {4'b1010, lo, rw};
  endfunction

  task automatic cur_read(input logic [7:0] exp, input string req);
    logic a; logic [7:0] d;
    bus_start();
    put_byte(hdr(strap, 1'b1), a);
    chk(a, "R3 read header ack", a, 1);
    get_byte(1'b0, d);
    bus_stop();
    chk(d == exp, req, d, exp);
  endtask

  task automatic rand_read(input logic [7:0] adr, input int n, input string req);
    logic a; logic [7:0] d;
    bus_start();
    put_byte(hdr(strap, 1'b0), a);
    chk(a, "R3 write header ack", a, 1);
    put_byte(adr, a);
    chk(a, "R3 pointer ack", a, 1);
    bus_start();
    put_byte(hdr(strap, 1'b1), a);
    chk(a, "R6 read header ack", a, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, d);
      chk(d == pat((adr + i) & 255), req, d, pat((adr + i) & 255));
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    hw(5);
    rst_n = 1'b1;
    hw(5);

    // R1: reset state
    chk(sda_oe == 1'b0, "R1 pull-down released", sda_oe, 0);
    cur_read(8'h00, "R1 pointer 00h and storage 00h");

    // R2: strap x address sweep, header-only writes
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int l = 0; l < 8; l++) begin
        bus_start();
        put_byte(hdr(3'(l), 1'b0), a);
        bus_stop();
        chk(a == (l == s), "R2 address match", a, (l == s));
      end
    end
    strap = 3'b011;
    bus_start();
    put_byte({4'b0010, strap, 1'b0}, a);
    bus_stop();
    chk(a == 1'b0, "R2 wrong prefix ignored", a, 0);

    // R4/R3/R8: fill the whole space in one wrapping burst
    bus_start();
    put_byte(hdr(strap, 1'b0), a);
    chk(a, "R3 header ack", a, 1);
    put_byte(8'h00, a);
    chk(a, "R4 pointer load ack", a, 1);
    for (int i = 0; i < 256; i++) begin
      put_byte(pat(i), a);
      chk(a, "R3 data ack", a, 1);
    end
    bus_stop();

    // R5/R8: pointer wrapped to 00h and persists across transactions
    cur_read(pat(0), "R8 write wrap then R5 current read");
    cur_read(pat(1), "R5 pointer persists");

    // R6/R7/R8: burst straddling FFh
    rand_read(8'hFE, 4, "R8 read wrap burst");
    cur_read(pat(2), "R7 pointer after burst");

    // R7: full-space acknowledged burst
    rand_read(8'h00, 256, "R7 sequential full sweep");
    rand_read(8'h80, 1, "R6 random read 80h");
    rand_read(8'h07, 1, "R6 random read 07h");
    cur_read(pat(8), "R5 after random read");

    // R2: non-matching header followed by a would-be pointer byte
    oe_seen = 1'b0;
    bus_start();
    put_byte(hdr(3'b100, 1'b0), a);
    chk(a == 1'b0, "R2 no ack", a, 0);
    put_byte(8'h40, a);
    chk(a == 1'b0, "R2 pointer byte ignored", a, 0);
    bus_stop();
    chk(oe_seen == 1'b0, "R2 SDA never pulled", oe_seen, 0);
    cur_read(pat(9), "R2 pointer untouched");

    // R9: STOP mid data byte
    bus_start();
    put_byte(hdr(strap, 1'b0), a);
    put_byte(8'h10, a);
    put_bits(8'h55, 4);
    bus_stop();
    cur_read(pat(16), "R9 STOP mid byte stores nothing");

    // R9: repeated START mid data byte
    bus_start();
    put_byte(hdr(strap, 1'b0), a);
    put_byte(8'h30, a);
    put_bits(8'hAA, 3);
    bus_start();
    put_byte(hdr(strap, 1'b1), a);
    chk(a, "R9 header after restart ack", a, 1);
    get_byte(1'b0, d);
    bus_stop();
    chk(d == pat(48), "R9 restart mid byte", d, pat(48));

    // R4: single byte write, read back, neighbour intact
    bus_start();
    put_byte(hdr(strap, 1'b0), a);
    put_byte(8'h80, a);
    put_byte(8'hC3, a);
    chk(a, "R4 data ack", a, 1);
    bus_stop();
    cur_read(pat(129), "R4 pointer advanced after write");
    bus_start();
    put_byte(hdr(strap, 1'b0), a);
    put_byte(8'h80, a);
    bus_start();
    put_byte(hdr(strap, 1'b1), a);
    get_byte(1'b0, d);
    bus_stop();
    chk(d == 8'hC3, "R4 stored byte", d, 8'hC3);

    // R10
    chk(oe_hi_viol == 0, "R10 no change while SCL high", oe_hi_viol, 0);
    chk(oe_toggles > 0, "R10 pull-down exercised", oe_toggles, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule